// File: doc/BRIEF.md
# Write-Through Invalidate Snooping Cache

This block is a small private cache for one processor that shares an atomic bus with other caches of the same kind. It is direct-mapped, keeps one data word per line, and writes every store straight through to the bus. Each line is either Invalid or Valid. Coherence comes from snooping. When another master's write appears on the bus with an address that matches a Valid line, that local copy is dropped. The next read of that address then fetches the fresh value from memory.

The processor side is a request/ready handshake. The processor raises a request with the command, address and write data, and holds them steady until ready is high in a cycle. A read hit completes in the cycle the request is presented. Any operation that needs the bus keeps ready low until its bus transaction has ended. The bus side asks for the bus and waits for a grant. It drives command and address only in the granted cycle, and for a read it waits for the data-valid strobe. A separate snoop port sees every bus transaction together with the ID of the master that issued it.

Top module: `wt_snoop_cache`

## Requirements
- R1: After reset every line is Invalid, bus_req and cpu_ready are low, and the first read of any address goes to the bus.
- R2: A read that misses raises bus_req in the cycle after the request is taken. In the granted cycle it drives bus_cmd_valid with bus_cmd_we=0 and bus_addr equal to cpu_addr. It takes bus_rdata in the cycle bus_rvalid is high, and returns that word with cpu_ready one cycle later. The line is then Valid.
- R3: A read that hits a Valid line (index cpu_addr[5:2], tag cpu_addr[31:6]) returns the stored word with cpu_ready in the same cycle and does not raise bus_req.
- R4: Every write, hit or miss, raises bus_req. In the granted cycle it drives bus_cmd_valid with bus_cmd_we=1, bus_addr=cpu_addr and bus_wdata=cpu_wdata, and cpu_ready follows one cycle after the grant.
- R5: A write that hits updates the stored word, so a later read of that address hits and returns the written value.
- R6: A write that misses does not allocate: a later read of that address goes to the bus.
- R7: A snooped write (snp_valid=1, snp_we=1) from a master whose snp_id differs from MY_ID, to an address that matches a Valid line, makes that line Invalid.
- R8: A snooped write whose snp_id equals MY_ID leaves the line Valid.
- R9: A snooped read (snp_we=0), or a snooped write whose tag differs from the one stored at that index, leaves the line Valid.
- R10: bus_req stays high until bus_gnt is seen, and bus_cmd_valid is high only in a cycle where bus_req and bus_gnt are both high.
- R11: cpu_ready is low in every cycle in which bus_req is high.
- R12: Two addresses with the same index and different tags share one line: a fill for one evicts the other, while lines at other indexes are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor operation request, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Byte address of the operation |
| cpu_wdata | input | DW | Store data |
| cpu_rdata | output | DW | Load data, valid with cpu_ready |
| cpu_ready | output | 1 | Operation completes in this cycle |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd_valid | output | 1 | Command valid (granted cycle only) |
| bus_cmd_we | output | 1 | 1 = bus write, 0 = bus read |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data |
| bus_rvalid | input | 1 | Read data valid strobe |
| snp_valid | input | 1 | A transaction is on the bus |
| snp_we | input | 1 | Observed transaction is a write |
| snp_id | input | IDW | ID of the master that issued it |
| snp_addr | input | AW | Address of the observed transaction |

## Verification
Loads are tried cold, warm, after a store to the same word, after a non-allocating store miss, and after each kind of snooped transaction. Each case tells a hit (same-cycle ready, no request) from a miss (a full bus read). Snoop patterns vary one field at a time: a foreign write, a write tagged with the block's own ID, a foreign read, and a foreign write to a different tag at the same index. This separates the one case that must invalidate from the three that must not. Grant latency is varied so that request holding and the quiet command lines are observed over several waiting cycles. An index conflict shows eviction without disturbing a neighbouring line.

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LINES = 16,
  parameter int IDW = 2,
  parameter logic [IDW-1:0] MY_ID = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cpu_req,
  input  logic           cpu_we,
  input  logic [AW-1:0]  cpu_addr,
  input  logic [DW-1:0]  cpu_wdata,
  output logic [DW-1:0]  cpu_rdata,
  output logic           cpu_ready,
  output logic           bus_req,
  input  logic           bus_gnt,
  output logic           bus_cmd_valid,
  output logic           bus_cmd_we,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_wdata,
  input  logic [DW-1:0]  bus_rdata,
  input  logic           bus_rvalid,
  input  logic           snp_valid,
  input  logic           snp_we,
  input  logic [IDW-1:0] snp_id,
  input  logic [AW-1:0]  snp_addr
);
  localparam int IW = $clog2(LINES);
  localparam int OW = 2;
  localparam int TW = AW - IW - OW;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_DONE} st_t;
  st_t st_q;

  logic [LINES-1:0] vld_q;
  logic [TW-1:0]    tag_q [LINES];
  logic [DW-1:0]    dat_q [LINES];

  wire [IW-1:0] c_idx = cpu_addr[OW +: IW];
  wire [TW-1:0] c_tag = cpu_addr[AW-1 -: TW];
  wire [IW-1:0] s_idx = snp_addr[OW +: IW];
  wire [TW-1:0] s_tag = snp_addr[AW-1 -: TW];

  wire c_hit   = vld_q[c_idx] && (tag_q[c_idx] == c_tag);
  wire s_kill  = snp_valid && snp_we && (snp_id != MY_ID) &&
                 vld_q[s_idx] && (tag_q[s_idx] == s_tag);
  wire granted = (st_q == S_REQ) && bus_gnt;
  wire fill    = (st_q == S_WAIT) && bus_rvalid;

  assign bus_req       = (st_q == S_REQ);
  assign bus_cmd_valid = granted;
  assign bus_cmd_we    = granted && cpu_we;
  assign bus_addr      = granted ? cpu_addr : '0;
  assign bus_wdata     = (granted && cpu_we) ? cpu_wdata : '0;
  assign cpu_rdata     = dat_q[c_idx];
  assign cpu_ready     = (st_q == S_DONE) ||
                         ((st_q == S_IDLE) && cpu_req && !cpu_we && c_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= S_IDLE;
    else begin
      case (st_q)
        S_IDLE: if (cpu_req && (cpu_we || !c_hit)) st_q <= S_REQ;
        S_REQ:  if (bus_gnt) st_q <= cpu_we ? S_DONE : S_WAIT;
        S_WAIT: if (bus_rvalid) st_q <= S_DONE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else begin
      if (s_kill) vld_q[s_idx] <= 1'b0;
      if (fill)   vld_q[c_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      tag_q[c_idx] <= c_tag;
      dat_q[c_idx] <= bus_rdata;
    end else if (granted && cpu_we && c_hit) begin
      dat_q[c_idx] <= cpu_wdata;
    end
  end
endmodule

// File: rtl/wt_snoop_cache_chk.sv
module wt_snoop_cache_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_ready,
  input logic [AW-1:0] cpu_addr,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          bus_cmd_valid,
  input logic          bus_cmd_we,
  input logic [AW-1:0] bus_addr
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!bus_req && !cpu_ready));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req);

  p_cmd_in_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_valid |-> (bus_req && bus_gnt));

  p_no_ready_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !cpu_ready);

  p_cmd_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_valid |-> (bus_addr == cpu_addr));

  p_write_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_valid && bus_cmd_we) |=> cpu_ready);
endmodule

bind wt_snoop_cache wt_snoop_cache_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .cpu_addr(cpu_addr),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_valid(bus_cmd_valid),
  .bus_cmd_we(bus_cmd_we), .bus_addr(bus_addr)
);

// File: tb/tb_wt_snoop_cache.sv
module tb_wt_snoop_cache;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cpu_req = 0, cpu_we = 0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready;
  logic        bus_req, bus_gnt = 0, bus_cmd_valid, bus_cmd_we;
  logic [31:0] bus_addr, bus_wdata, bus_rdata = '0;
  logic        bus_rvalid = 0;
  logic        snp_valid = 0, snp_we = 0;
  logic [1:0]  snp_id = '0;
  logic [31:0] snp_addr = '0;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [31:0] mem [logic [31:0]];

  wt_snoop_cache #(.MY_ID(2'd0)) dut (.*);

  always #10 clk = ~clk;

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a * 3 + 32'h1234_5000;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        check(0, "WDOG", "cycles", cyc, 20000);
        summary();
      end
    end
  end

  task automatic cpu_op(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        input int gdly, input string req,
                        output logic [31:0] rd, output logic used_bus);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    used_bus = 0; rd = '0;
    #1;
    if (cpu_ready) begin
      rd = cpu_rdata;
      @(posedge clk);
    end else begin
      @(negedge clk);
      used_bus = 1;
      for (int i = 0; i < gdly; i++) begin
        check(bus_req === 1'b1, "R10", "bus_req held", {31'd0, bus_req}, 1);
        check(bus_cmd_valid === 1'b0, "R10", "cmd without grant", {31'd0, bus_cmd_valid}, 0);
        check(cpu_ready === 1'b0, "R11", "ready while busy", {31'd0, cpu_ready}, 0);
        @(negedge clk);
      end
      check(bus_req === 1'b1, we ? "R4" : "R2", "bus_req", {31'd0, bus_req}, 1);
      bus_gnt = 1;
      #1;
      check(bus_cmd_valid === 1'b1, we ? "R4" : "R2", "cmd_valid", {31'd0, bus_cmd_valid}, 1);
      check(bus_cmd_we === we, we ? "R4" : "R2", "cmd_we", {31'd0, bus_cmd_we}, {31'd0, we});
      check(bus_addr === a, we ? "R4" : "R2", "bus_addr", bus_addr, a);
      if (we) begin
        check(bus_wdata === wd, "R4", "bus_wdata", bus_wdata, wd);
        mem[a] = wd;
      end
      @(negedge clk);
      bus_gnt = 0;
      if (!we) begin
        #1;
        check(cpu_ready === 1'b0, "R11", "ready before data", {31'd0, cpu_ready}, 0);
        bus_rvalid = 1; bus_rdata = mem_rd(a);
        @(negedge clk);
        bus_rvalid = 0; bus_rdata = '0;
      end
      #1;
      check(cpu_ready === 1'b1, we ? "R4" : "R2", "ready after bus", {31'd0, cpu_ready}, 1);
      rd = cpu_rdata;
      @(posedge clk);
    end
    @(negedge clk);
    cpu_req = 0; cpu_we = 0;
  endtask

  task automatic t_read(input logic [31:0] a, input bit exp_hit, input string req);
    logic [31:0] rd; logic ub;
    cpu_op(0, a, '0, 1, req, rd, ub);
    check(ub === !exp_hit, req, exp_hit ? "expected hit" : "expected miss", {31'd0, ub}, {31'd0, !exp_hit});
    check(rd === mem_rd(a), req, "read data", rd, mem_rd(a));
  endtask

  task automatic t_write(input logic [31:0] a, input logic [31:0] d, input string req);
    logic [31:0] rd; logic ub;
    cpu_op(1, a, d, 2, req, rd, ub);
    check(ub === 1'b1, "R4", "write uses bus", {31'd0, ub}, 1);
  endtask

  task automatic snoop(input logic we, input logic [1:0] id, input logic [31:0] a);
    @(negedge clk);
    snp_valid = 1; snp_we = we; snp_id = id; snp_addr = a;
    if (we) mem[a] = mem_rd(a) ^ 32'hFFFF_0000;
    @(negedge clk);
    snp_valid = 0; snp_we = 0; snp_id = '0; snp_addr = '0;
  endtask

  localparam logic [31:0] A = 32'h0000_0100;
  localparam logic [31:0] B = 32'h0000_0204;
  localparam logic [31:0] C = 32'h0000_0108;
  localparam logic [31:0] D = 32'h0000_1108;

  task automatic t_reset();
    @(negedge clk);
    check(bus_req === 1'b0, "R1", "bus_req after reset", {31'd0, bus_req}, 0);
    check(cpu_ready === 1'b0, "R1", "ready after reset", {31'd0, cpu_ready}, 0);
  endtask

  task automatic t_miss_then_hit();
    logic [31:0] rd; logic ub;
    cpu_op(0, A, '0, 4, "R1", rd, ub);
    check(ub === 1'b1, "R1", "cold read misses", {31'd0, ub}, 1);
    check(rd === mem_rd(A), "R2", "fill data", rd, mem_rd(A));
    t_read(A, 1, "R3");
  endtask

  task automatic t_write_hit();
    t_write(A, 32'hCAFE_0001, "R4");
    t_read(A, 1, "R5");
  endtask

  task automatic t_write_miss();
    t_write(B, 32'hBEEF_0002, "R6");
    t_read(B, 0, "R6");
    t_read(B, 1, "R6");
  endtask

  task automatic t_snoop_cases();
    snoop(1, 2'd1, A);
    t_read(A, 0, "R7");
    t_read(C, 0, "R8");
    snoop(1, 2'd0, C);
    mem[C] = mem_rd(C) ^ 32'hFFFF_0000;
    t_read(C, 1, "R8");
    snoop(0, 2'd2, C);
    t_read(C, 1, "R9");
    snoop(1, 2'd3, D);
    t_read(C, 1, "R9");
  endtask

  task automatic t_conflict();
    t_read(D, 0, "R12");
    t_read(C, 0, "R12");
    t_read(A, 1, "R12");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_miss_then_hit();
    t_write_hit();
    t_write_miss();
    t_snoop_cases();
    t_conflict();
    repeat (3) @(posedge clk);
    summary();
  end
endmodule